// File: doc/BRIEF.md
# OLED Panel Power-Up Command Sequencer

This block brings a 128-column monochrome OLED controller out of power-up over an 8-bit parallel write bus. A single `start` pulse first holds the panel's reset line low for a fixed number of clocks. The block then steps through a built-in list of 25 command bytes. Each byte goes out as its own bus write with D/C low. The list is adjusted by two select pins: one picks a 64-row or 32-row panel, the other picks a 180-degree rotated mounting. Both selects are captured on the `start` cycle. When the last byte of the list has been written, `done` rises and stays high until reset.

Once running, the block takes blank, unblank and contrast requests on a valid/ready channel. A request is held in a single-entry slot. `req_ready` is high only while that slot is empty, so the source must keep `req_valid`, `req_kind` and `req_value` steady until it sees `req_ready` high at a clock edge. A request that arrives before `done` is kept in the slot and is only carried out after the power-up list has finished. `busy` is high while the power-up runs, while a bus write is in progress, or while a request is waiting.

Top module: `oled_init_seq`

## Requirements
- R1: Reset state:
  - `bus_wr` is low; `bus_dc`, `bus_rd` and `panel_rst_n` are high.
  - `done` and `busy` are low; `req_ready` is high.
- R2: `panel_rst_n` goes low on the first clock edge at which `start` is sampled high.
  - It stays low for exactly RST_CYCLES clocks.
  - The first bus write pulls `bus_dc` low one clock after `panel_rst_n` returns high.
  - No WR pulse occurs while `panel_rst_n` is low.
- R3: Each byte is a separate write:
  - one setup clock with `bus_dc` low and WR low;
  - then WR high for exactly WR_PULSE clocks;
  - then one hold clock with WR low.
  - `bus_data` is unchanged through all of these clocks, and `bus_dc` returns high for at least one clock between bytes.
- R4: For a 64-row, unrotated panel the power-up list is, in order: AE, D5, 80, A8, 3F, D3, 00, 40, 8D, 14, 20, 01, A1, C0, DA, 12, D9, F1, DB, 40, 81, CF, A4, A6, AF (hex).
- R5: With `rows64` low, three bytes change and the rest of the list is the same:
  - list position 4 (multiplex count) is 1F;
  - position 15 (COM pin layout) is 02;
  - position 21 (default contrast) is 8F.
- R6: With `rot180` high, the segment remap byte is A0 and the COM scan byte is C8. With `rot180` low they are A1 and C0.
- R7: `done` rises exactly RST_CYCLES + 1 + 25*(WR_PULSE+3) clocks after the `start` edge and stays high.
  - With no request pending, `busy` is then low.
- R8: Requests are encoded by `req_kind`:
  - 2'b00 (blank) writes AE;
  - 2'b01 (unblank) writes AF;
  - 2'b10 or 2'b11 (contrast) writes 81 and then `req_value`, as two separate writes.
- R9: A request accepted before `done` produces no bus write until after the final AF of the power-up list. The power-up timing is unchanged by it.
- R10: After a request is accepted, `req_ready` stays low until the last byte of that request has been launched.
- R11: `bus_rd` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the power-up sequence (accepted only before the first run) |
| rows64 | input | 1 | 1 = 64-row panel, 0 = 32-row panel |
| rot180 | input | 1 | 1 = panel mounted rotated by 180 degrees |
| req_valid | input | 1 | Runtime request valid |
| req_ready | output | 1 | Request slot empty |
| req_kind | input | 2 | 00 blank, 01 unblank, 1x contrast |
| req_value | input | 8 | Contrast value |
| bus_data | output | 8 | Parallel bus byte |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dc | output | 1 | Data/command select; low for every command byte |
| bus_rd | output | 1 | Read strobe, held inactive high |
| panel_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | Sequence, write or request in progress |
| done | output | 1 | Power-up list complete |

## Verification
The `start` edge is numbered cycle 0, and the panel reset is due low at cycles 0 through RST_CYCLES-1. The first falling D/C is due at cycle RST_CYCLES+1, and `done` is due at cycle RST_CYCLES+1+25*(WR_PULSE+3). That is 130 with the default parameters. The bench counts falling clock edges from the `start` edge and compares each of these events to its exact cycle number. Every bus write is captured between the fall and rise of D/C, where its setup clock, pulse width, hold clock and data stability are measured. Request results are compared as byte streams after `busy` drops, and `req_ready` is sampled one clock after acceptance.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  localparam int INIT_LEN = 25;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RESET, SQ_INIT, SQ_RUN} seq_state_t;
  typedef enum logic [1:0] {WB_IDLE, WB_SETUP, WB_PULSE, WB_HOLD} wb_state_t;

  localparam logic [7:0] CMD_OFF      = 8'hAE;
  localparam logic [7:0] CMD_ON       = 8'hAF;
  localparam logic [7:0] CMD_CONTRAST = 8'h81;

  // Power-up command list; height and rotation change five positions
  function automatic logic [7:0] init_byte(input logic [4:0] idx,
                                           input logic tall, input logic rot);
    logic [7:0] b;
    case (idx)
      5'd0:  b = CMD_OFF;
      5'd1:  b = 8'hD5;
      5'd2:  b = 8'h80;
      5'd3:  b = 8'hA8;
      5'd4:  b = tall ? 8'h3F : 8'h1F;
      5'd5:  b = 8'hD3;
      5'd6:  b = 8'h00;
      5'd7:  b = 8'h40;
      5'd8:  b = 8'h8D;
      5'd9:  b = 8'h14;
      5'd10: b = 8'h20;
      5'd11: b = 8'h01;
      5'd12: b = rot ? 8'hA0 : 8'hA1;
      5'd13: b = rot ? 8'hC8 : 8'hC0;
      5'd14: b = 8'hDA;
      5'd15: b = tall ? 8'h12 : 8'h02;
      5'd16: b = 8'hD9;
      5'd17: b = 8'hF1;
      5'd18: b = 8'hDB;
      5'd19: b = 8'h40;
      5'd20: b = CMD_CONTRAST;
      5'd21: b = tall ? 8'hCF : 8'h8F;
      5'd22: b = 8'hA4;
      5'd23: b = 8'hA6;
      default: b = CMD_ON;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/oled_bus_writer.sv
module oled_bus_writer #(
  parameter int PULSE_CYC = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              idle_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_o,
  output logic              dc_o
);
  import oled_seq_pkg::*;

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  wb_state_t        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= WB_IDLE;
      cnt    <= '0;
      data_o <= '0;
    end else begin
      case (st)
        WB_IDLE: if (start_i) begin
          data_o <= byte_i;
          st     <= WB_SETUP;
        end
        WB_SETUP: begin
          cnt <= '0;
          st  <= WB_PULSE;
        end
        WB_PULSE: begin
          if (cnt == CNT_W'(PULSE_CYC - 1)) st <= WB_HOLD;
          else cnt <= cnt + 1'b1;
        end
        default: st <= WB_IDLE;
      endcase
    end
  end

  assign idle_o = (st == WB_IDLE);
  assign wr_o   = (st == WB_PULSE);
  assign dc_o   = (st == WB_IDLE);

  // R3
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_o) |-> $past(!dc_o));
  // R3
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> (!dc_o && $stable(data_o)));

endmodule

// File: rtl/oled_req_slot.sv
module oled_req_slot #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [VAL_W-1:0] in_val,
  input  logic             pop_i,
  output logic             full_o,
  output logic [1:0]       kind_o,
  output logic [VAL_W-1:0] val_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      kind_o <= '0;
      val_o  <= '0;
    end else if (pop_i) begin
      full_o <= 1'b0;
    end else if (in_valid && !full_o) begin
      full_o <= 1'b1;
      kind_o <= in_kind;
      val_o  <= in_val;
    end
  end

  assign in_ready = !full_o;

  // R10
  slot_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/oled_cmd_seq.sv
module oled_cmd_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tall_i,
  input  logic       rot_i,
  input  logic       wr_idle_i,
  output logic       issue_o,
  output logic [7:0] byte_o,
  input  logic       slot_full_i,
  input  logic [1:0] slot_kind_i,
  input  logic [7:0] slot_val_i,
  output logic       pop_o,
  output logic       panel_rst_n_o,
  output logic       done_o,
  output logic       active_o
);
  import oled_seq_pkg::*;

  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam int IDX_W = $clog2(INIT_LEN + 1);

  seq_state_t       st;
  logic [RC_W-1:0]  rst_cnt;
  logic [IDX_W-1:0] idx;
  logic             tall_q, rot_q, second_q;

  always_comb begin
    issue_o = 1'b0;
    byte_o  = '0;
    pop_o   = 1'b0;
    if (st == SQ_INIT && wr_idle_i && idx < IDX_W'(INIT_LEN)) begin
      issue_o = 1'b1;
      byte_o  = init_byte(5'(idx), tall_q, rot_q);
    end else if (st == SQ_RUN && wr_idle_i && slot_full_i) begin
      issue_o = 1'b1;
      if (slot_kind_i[1]) begin
        byte_o = second_q ? slot_val_i : CMD_CONTRAST;
        pop_o  = second_q;
      end else begin
        byte_o = slot_kind_i[0] ? CMD_ON : CMD_OFF;
        pop_o  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      rst_cnt  <= '0;
      idx      <= '0;
      tall_q   <= 1'b0;
      rot_q    <= 1'b0;
      second_q <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start_i) begin
          st      <= SQ_RESET;
          rst_cnt <= '0;
          idx     <= '0;
          tall_q  <= tall_i;
          rot_q   <= rot_i;
        end
        SQ_RESET: begin
          if (rst_cnt == RC_W'(RST_CYCLES - 1)) st <= SQ_INIT;
          else rst_cnt <= rst_cnt + 1'b1;
        end
        SQ_INIT: begin
          if (issue_o) idx <= idx + 1'b1;
          else if (idx == IDX_W'(INIT_LEN) && wr_idle_i) st <= SQ_RUN;
        end
        default: if (issue_o && slot_kind_i[1]) second_q <= !second_q;
      endcase
    end
  end

  assign panel_rst_n_o = (st != SQ_RESET);
  assign done_o        = (st == SQ_RUN);
  assign active_o      = (st == SQ_RESET) || (st == SQ_INIT);

  // R2
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n_o |-> wr_idle_i);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  // R9
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !pop_o);

endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq #(
  parameter int RST_CYCLES = 4,
  parameter int WR_PULSE   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rows64,
  input  logic       rot180,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_value,
  output logic [7:0] bus_data,
  output logic       bus_wr,
  output logic       bus_dc,
  output logic       bus_rd,
  output logic       panel_rst_n,
  output logic       busy,
  output logic       done
);

  logic       wr_idle, issue, slot_full, pop, active;
  logic [7:0] issue_byte, slot_val;
  logic [1:0] slot_kind;

  oled_req_slot #(.VAL_W(8)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_kind(req_kind), .in_val(req_value),
    .pop_i(pop), .full_o(slot_full), .kind_o(slot_kind), .val_o(slot_val)
  );

  oled_cmd_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .tall_i(rows64), .rot_i(rot180), .wr_idle_i(wr_idle),
    .issue_o(issue), .byte_o(issue_byte),
    .slot_full_i(slot_full), .slot_kind_i(slot_kind), .slot_val_i(slot_val),
    .pop_o(pop), .panel_rst_n_o(panel_rst_n), .done_o(done), .active_o(active)
  );

  oled_bus_writer #(.PULSE_CYC(WR_PULSE), .DATA_W(8)) u_wr (
    .clk(clk), .rst_n(rst_n), .start_i(issue), .byte_i(issue_byte),
    .idle_o(wr_idle), .data_o(bus_data), .wr_o(bus_wr), .dc_o(bus_dc)
  );

  assign bus_rd = 1'b1;
  assign busy   = active || !wr_idle || slot_full;

endmodule

// File: tb/oled_init_seq_bench.sv
module oled_init_seq_bench;

  localparam int RST = 4;
  localparam int P   = 2;
  localparam int DONE_AT = RST + 1 + 25 * (P + 3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rows64 = 1, rot180 = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_value = 0;
  logic req_ready, bus_wr, bus_dc, bus_rd, panel_rst_n, busy, done;
  logic [7:0] bus_data;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  oled_init_seq #(.RST_CYCLES(RST), .WR_PULSE(P)) u_oled_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rows64(rows64), .rot180(rot180),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_value(req_value), .bus_data(bus_data), .bus_wr(bus_wr),
    .bus_dc(bus_dc), .bus_rd(bus_rd), .panel_rst_n(panel_rst_n),
    .busy(busy), .done(done)
  );

  // Bus monitor: captures each write between D/C fall and rise
  logic [7:0] log_b [0:63];
  int log_w [0:63];
  int nlog = 0, hi_cnt = 0, shape_err = 0, rd_err = 0;
  logic [7:0] cur_b = 0;
  logic prev_dc = 1, prev_wr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_dc && prev_dc) begin
        cur_b = bus_data; hi_cnt = 0;
        if (bus_wr) shape_err++;
      end
      if (!bus_dc && bus_data != cur_b) shape_err++;
      if (bus_wr && bus_dc) shape_err++;
      if (bus_wr) hi_cnt++;
      if (bus_dc && !prev_dc) begin
        if (prev_wr) shape_err++;
        if (nlog < 64) begin log_b[nlog] = cur_b; log_w[nlog] = hi_cnt; end
        nlog++;
      end
      if (!bus_rd) rd_err++;
      prev_dc = bus_dc; prev_wr = bus_wr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input int i, input bit tall, input bit rot);
    logic [7:0] l [0:24];
    l = '{8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h3F, 8'hD3, 8'h00, 8'h40, 8'h8D, 8'h14,
          8'h20, 8'h01, 8'hA1, 8'hC0, 8'hDA, 8'h12, 8'hD9, 8'hF1, 8'hDB, 8'h40,
          8'h81, 8'hCF, 8'hA4, 8'hA6, 8'hAF};
    if (!tall) begin l[4] = 8'h1F; l[15] = 8'h02; l[21] = 8'h8F; end
    if (rot) begin l[12] = 8'hA0; l[13] = 8'hC8; end
    return l[i];
  endfunction

  task automatic do_reset();
    rst_n = 0; start = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; nlog = 0; shape_err = 0; rd_err = 0; prev_dc = 1; prev_wr = 0;
    @(negedge clk);
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((busy || !bus_dc) && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic send_req(input logic [1:0] k, input logic [7:0] v);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_value = v;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Drives start and measures reset/first-write/done timing; optional queued contrast
  task automatic run_init(input bit tall, input bit rot, input bit queue_req, input string tag);
    int rst_low = 0, first_dc = -1, done_at = -1;
    rows64 = tall; rot180 = rot;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    for (int n = 0; n < 400 && done_at < 0; n++) begin
      @(negedge clk);
      start = 0;
      if (!panel_rst_n) begin
        rst_low++;
        chk(n < RST, "R2 reset window", n, RST - 1);
      end
      if (!bus_dc && first_dc < 0) first_dc = n;
      if (done) done_at = n;
      if (queue_req && n == 20) begin
        chk(req_ready == 1, "R9 slot open during init", req_ready, 1);
        req_valid = 1; req_kind = 2'b10; req_value = 8'h33;
      end
      if (queue_req && n == 21) begin
        req_valid = 0;
        chk(req_ready == 0, "R10 ready low after accept", req_ready, 0);
        chk(busy == 1, "R10 busy while held", busy, 1);
      end
    end
    chk(rst_low == RST, {"R2 reset length ", tag}, rst_low, RST);
    chk(first_dc == RST + 1, {"R2 first write ", tag}, first_dc, RST + 1);
    chk(done_at == DONE_AT, {"R7 done cycle ", tag}, done_at, DONE_AT);
    chk(nlog == 25, {"R9 no request bytes before done ", tag}, nlog, 25);
    wait_quiet();
    chk(done == 1, "R7 done stays", done, 1);
    chk(busy == 0, "R7 busy clear", busy, 0);
    for (int i = 0; i < 25; i++) begin
      chk(log_b[i] == exp_cmd(i, tall, rot),
          tall ? (rot ? "R6 list" : "R4 list") : "R5 list",
          log_b[i], exp_cmd(i, tall, rot));
      chk(log_w[i] == P, "R3 pulse width", log_w[i], P);
    end
    if (queue_req) begin
      chk(nlog == 27, "R9 queued count", nlog, 27);
      chk(log_b[25] == 8'h81, "R9 queued contrast cmd", log_b[25], 8'h81);
      chk(log_b[26] == 8'h33, "R9 queued contrast value", log_b[26], 8'h33);
      chk(req_ready == 1, "R10 ready after drain", req_ready, 1);
    end else begin
      chk(nlog == 25, "R4 list length", nlog, 25);
    end
    chk(shape_err == 0, "R3 write shape", shape_err, 0);
    chk(rd_err == 0, "R11 read strobe", rd_err, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(bus_wr == 0, "R1 wr", bus_wr, 0);
    chk(bus_dc == 1, "R1 dc", bus_dc, 1);
    chk(bus_rd == 1, "R1 rd", bus_rd, 1);
    chk(panel_rst_n == 1, "R1 panel reset", panel_rst_n, 1);
    chk(done == 0, "R1 done", done, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
  endtask

  task automatic t_requests();
    int base;
    do_reset();
    run_init(1, 0, 0, "64");
    base = nlog;
    send_req(2'b00, 8'h00); wait_quiet();
    send_req(2'b01, 8'h00); wait_quiet();
    send_req(2'b10, 8'h5A); wait_quiet();
    send_req(2'b11, 8'hC3); wait_quiet();
    chk(nlog - base == 6, "R8 request byte count", nlog - base, 6);
    chk(log_b[base]   == 8'hAE, "R8 blank",        log_b[base],   8'hAE);
    chk(log_b[base+1] == 8'hAF, "R8 unblank",      log_b[base+1], 8'hAF);
    chk(log_b[base+2] == 8'h81, "R8 contrast cmd", log_b[base+2], 8'h81);
    chk(log_b[base+3] == 8'h5A, "R8 contrast val", log_b[base+3], 8'h5A);
    chk(log_b[base+4] == 8'h81, "R8 kind 11 cmd",  log_b[base+4], 8'h81);
    chk(log_b[base+5] == 8'hC3, "R8 kind 11 val",  log_b[base+5], 8'hC3);
    chk(shape_err == 0, "R3 request write shape", shape_err, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset_state();
    t_requests();
    do_reset();
    run_init(0, 1, 0, "32 rotated");
    do_reset();
    run_init(0, 0, 0, "32");
    do_reset();
    run_init(1, 1, 1, "64 rotated queued");
    finish_run();
  end

endmodule